// File: doc/BRIEF.md
# Parallel-Compare Memory Test Mode

This block holds the storage and test-mode logic of a one-bit-wide dynamic memory. The array is built from eight equal sections. A strobe decoder upstream classifies each memory cycle and passes a cycle code to the block. In normal operation every read and write reaches exactly one bit, selected by the full row and column address. Page cycles reuse the row taken by the last full access.

A refresh cycle in which CAS falls before RAS while write-enable is held low puts the block into a parallel test mode. In this mode a write stores the input bit at the same offset in all eight sections in one cycle. A read checks the eight stored bits against one another and returns a pass or fail level instead of a data bit. Three address bits then select nothing, so the array behaves as one eighth of its depth.

Either of the two ordinary refresh cycles returns the block to normal operation. The data output is enabled only while CAS is low.

Top module: `par_cmp_mem`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears test mode, sets `dout` to 0 and clears every array bit to 0.
- R2: `cyc_kind` is encoded as 0 idle, 1 read, 2 write, 3 read-modify-write, 4 page read, 5 page write, 6 RAS-only refresh, 7 CAS-before-RAS refresh, and it acts only while `cyc_valid` is 1. Outside test mode a write stores `din` at the single bit `{row_addr, col_addr}`. A read loads that bit into `dout`, where it is visible after the next rising edge and holds until the next read.
- R3: A valid code 7 with `we_n` low enables test mode from the following cycle on.
- R4: A valid code 6, or a valid code 7 with `we_n` high, disables test mode from the following cycle on. No other code changes the mode.
- R5: In test mode a write stores `din` at all eight bits whose addresses differ from the given address only in `row_addr[ROW_W-1]`, `col_addr[COL_W-1]` and `col_addr[0]`.
- R6: In test mode a read sets `dout` to 1 when those eight bits are all equal and to 0 when any of them differs.
- R7: In test mode, `row_addr[ROW_W-1]`, `col_addr[COL_W-1]` and `col_addr[0]` have no effect on which location a read or write uses.
- R8: Codes 4 and 5 use the row latched by the most recent valid code 1, 2 or 3, together with the current column, in either mode.
- R9: Code 3 loads `dout` from the contents as they were before the cycle and writes `din` in the same cycle, in either mode.
- R10: `dout_en` is 1 exactly while `cas_n` is 0. The output is high-impedance while CAS is high.
- R11: Refresh and idle codes leave the array contents and `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | Cycle code is valid this clock |
| cyc_kind | input | 3 | Cycle code from the strobe decoder |
| we_n | input | 1 | Write-enable level sampled with the cycle (active low) |
| cas_n | input | 1 | Column strobe level, gates the output |
| row_addr | input | ROW_W | Row address |
| col_addr | input | COL_W | Column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, or the pass/fail level in test mode |
| dout_en | output | 1 | Output drive enable (0 means high-impedance) |

## Verification
Directed sequences first write distinct bits to addresses that share an offset but sit in different sections. This separates single-bit addressing from the parallel write. Test-mode reads are then applied to offsets whose eight copies are all ones, all zeros, or mixed after one copy is changed in normal mode. These three cases separate an equality compare from an AND-only or OR-only reduction. Page and read-modify-write cycles are driven with don't-care bits toggled, which tests both the row latch and the read-before-write ordering. A long random run that concentrates traffic on a few rows mixes mode changes with every cycle code, so that the ordering of refresh against data cycles is also covered.

// File: rtl/pcm_pkg.sv
// Package: cycle codes and fixed section geometry shared by the test-mode block.
// Assumes the strobe decoder presents one code per clock with a valid flag.
package pcm_pkg;

    localparam int SEC_N = 8;
    localparam int SEC_W = 3;

    typedef enum logic [2:0] {
        CYC_IDLE = 3'd0,
        CYC_RD   = 3'd1,
        CYC_WR   = 3'd2,
        CYC_RMW  = 3'd3,
        CYC_PRD  = 3'd4,
        CYC_PWR  = 3'd5,
        CYC_ROR  = 3'd6,
        CYC_CBR  = 3'd7
    } cyc_e;

    // True for every code that samples the array onto the output.
    function automatic logic is_read(input cyc_e k);
        return (k == CYC_RD) || (k == CYC_RMW) || (k == CYC_PRD);
    endfunction

    // True for every code that stores the input bit.
    function automatic logic is_write(input cyc_e k);
        return (k == CYC_WR) || (k == CYC_RMW) || (k == CYC_PWR);
    endfunction

    // True for page codes that reuse the latched row.
    function automatic logic is_page(input cyc_e k);
        return (k == CYC_PRD) || (k == CYC_PWR);
    endfunction

    // True for full-address data codes that latch a new row.
    function automatic logic is_row_open(input cyc_e k);
        return (k == CYC_RD) || (k == CYC_WR) || (k == CYC_RMW);
    endfunction

endpackage

// File: rtl/pcm_mode_ctrl.sv
// Module: tracks entry to and exit from parallel test mode.
// Entry: refresh with CAS first and write-enable low. Exit: either plain refresh.
// Assumes cyc_kind is meaningful only while cyc_valid is high.
module pcm_mode_ctrl
    import pcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_valid,
    input  logic [2:0] cyc_kind,
    input  logic       we_n,
    output logic       test_mode
);

    cyc_e kind;

    // Purpose: view the raw code as the shared enum.
    always_comb kind = cyc_e'(cyc_kind);

    // Purpose: update the mode flag on refresh codes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_mode <= 1'b0;
        end else if (cyc_valid) begin
            case (kind)
                CYC_CBR: test_mode <= !we_n;
                CYC_ROR: test_mode <= 1'b0;
                default: test_mode <= test_mode;
            endcase
        end
    end

endmodule

// File: rtl/pcm_addr_map.sv
// Module: splits the address into a section index and an offset within a section.
// The section index is formed from the three bits that are ignored in test mode.
// Page codes take the row latched by the last full-address data code.
module pcm_addr_map
    import pcm_pkg::*;
#(
    parameter int ROW_W = 5,
    parameter int COL_W = 5,
    localparam int OFF_W = ROW_W + COL_W - SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_valid,
    input  logic [2:0]       cyc_kind,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [COL_W-1:0] col_addr,
    output logic [SEC_W-1:0] sec_sel,
    output logic [OFF_W-1:0] offset
);

    cyc_e             kind;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] eff_row;

    // Purpose: view the raw code as the shared enum.
    always_comb kind = cyc_e'(cyc_kind);

    // Purpose: hold the open row for later page cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (cyc_valid && is_row_open(kind)) begin
            row_q <= row_addr;
        end
    end

    // Purpose: choose the row in effect for this cycle.
    always_comb eff_row = (cyc_valid && is_page(kind)) ? row_q : row_addr;

    // Purpose: split the address into section and offset fields.
    always_comb begin
        sec_sel = {eff_row[ROW_W-1], col_addr[COL_W-1], col_addr[0]};
        offset  = {eff_row[ROW_W-2:0], col_addr[COL_W-2:1]};
    end

endmodule

// File: rtl/pcm_section_bank.sv
// Module: one eighth of the array, one bit wide, asynchronous read port.
// Cleared by reset. The write takes effect at the clock edge.
module pcm_section_bank #(
    parameter int OFF_W = 7,
    localparam int DEPTH = 1 << OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] offset,
    input  logic             wdata,
    output logic             rdata
);

    logic [DEPTH-1:0] cells;

    // Purpose: clear on reset, otherwise store one bit when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (wr_en) begin
            cells[offset] <= wdata;
        end
    end

    // Purpose: present the addressed bit.
    always_comb rdata = cells[offset];

endmodule

// File: rtl/pcm_read_merge.sv
// Module: forms the output bit from the eight section bits and registers it.
// Normal mode selects one bit. Test mode reports whether all eight are equal.
module pcm_read_merge
    import pcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_strobe,
    input  logic             test_mode,
    input  logic [SEC_N-1:0] sec_bits,
    input  logic [SEC_W-1:0] sec_sel,
    output logic             dout
);

    logic all_one;
    logic all_zero;
    logic rd_bit;

    // Purpose: reduce the section bits and pick the value for this mode.
    always_comb begin
        all_one  = &sec_bits;
        all_zero = ~|sec_bits;
        rd_bit   = test_mode ? (all_one | all_zero) : sec_bits[sec_sel];
    end

    // Purpose: hold the last read result on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (rd_strobe) begin
            dout <= rd_bit;
        end
    end

endmodule

// File: rtl/par_cmp_mem.sv
// Module: top of the test-mode memory block.
// Eight section banks share one offset. Normal writes enable one bank.
// Test writes enable all eight. Output drive follows the column strobe.
module par_cmp_mem
    import pcm_pkg::*;
#(
    parameter int ROW_W = 5,
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_valid,
    input  logic [2:0]       cyc_kind,
    input  logic             we_n,
    input  logic             cas_n,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [COL_W-1:0] col_addr,
    input  logic             din,
    output logic             dout,
    output logic             dout_en
);

    localparam int OFF_W = ROW_W + COL_W - SEC_W;

    cyc_e             kind;
    logic             test_mode;
    logic [SEC_W-1:0] sec_sel;
    logic [OFF_W-1:0] offset;
    logic [SEC_N-1:0] sec_bits;
    logic [SEC_N-1:0] sec_wr;
    logic             wr_any;
    logic             rd_any;

    // Purpose: decode the data-cycle strobes.
    always_comb begin
        kind   = cyc_e'(cyc_kind);
        wr_any = cyc_valid && is_write(kind);
        rd_any = cyc_valid && is_read(kind);
    end

    pcm_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .cyc_kind  (cyc_kind),
        .we_n      (we_n),
        .test_mode (test_mode)
    );

    pcm_addr_map #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .cyc_kind  (cyc_kind),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .sec_sel   (sec_sel),
        .offset    (offset)
    );

    for (genvar s = 0; s < SEC_N; s++) begin : g_sec
        // Purpose: enable this bank in test mode or when it is addressed.
        always_comb sec_wr[s] = wr_any && (test_mode || (sec_sel == SEC_W'(s)));

        pcm_section_bank #(
            .OFF_W (OFF_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sec_wr[s]),
            .offset (offset),
            .wdata  (din),
            .rdata  (sec_bits[s])
        );
    end

    pcm_read_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_any),
        .test_mode (test_mode),
        .sec_bits  (sec_bits),
        .sec_sel   (sec_sel),
        .dout      (dout)
    );

    // Purpose: drive the output only while the column strobe is low.
    always_comb dout_en = !cas_n;

endmodule

// File: rtl/par_cmp_mem_chk.sv
// Module: assertion checker bound to par_cmp_mem. Observes mode and read results.
module par_cmp_mem_chk
    import pcm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_valid,
    input logic [2:0]       cyc_kind,
    input logic             we_n,
    input logic             test_mode,
    input logic [SEC_N-1:0] sec_bits,
    input logic [SEC_W-1:0] sec_sel,
    input logic             dout
);

    logic is_rd;
    logic is_ref;
    logic eq8;

    always_comb begin
        is_rd  = cyc_valid && is_read(cyc_e'(cyc_kind));
        is_ref = cyc_valid && ((cyc_kind == 3'd6) || (cyc_kind == 3'd7));
        eq8    = (sec_bits == '0) || (sec_bits == '1);
    end

    p_wcbr_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 3'd7 && !we_n) |=> test_mode);

    p_refresh_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (cyc_kind == 3'd6 || (cyc_kind == 3'd7 && we_n))) |=> !test_mode);

    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ref |=> $stable(test_mode));

    p_cmp_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && test_mode) |=> (dout == $past(eq8)));

    p_single_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !test_mode) |=> (dout == $past(sec_bits[sec_sel])));

    p_dout_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> $stable(dout));

endmodule

bind par_cmp_mem par_cmp_mem_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .cyc_kind  (cyc_kind),
    .we_n      (we_n),
    .test_mode (test_mode),
    .sec_bits  (sec_bits),
    .sec_sel   (sec_sel),
    .dout      (dout)
);

// File: tb/par_cmp_mem_tb.sv
module par_cmp_mem_tb;

    localparam int RW = 5;
    localparam int CW = 5;
    localparam logic [2:0] K_IDLE = 3'd0, K_RD = 3'd1, K_WR = 3'd2, K_RMW = 3'd3,
                           K_PRD = 3'd4, K_PWR = 3'd5, K_ROR = 3'd6, K_CBR = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_valid = 1'b0;
    logic [2:0]    cyc_kind = 3'd0;
    logic          we_n = 1'b1;
    logic          cas_n = 1'b1;
    logic [RW-1:0] row_addr = '0;
    logic [CW-1:0] col_addr = '0;
    logic          din = 1'b0;
    logic          dout;
    logic          dout_en;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic          ref_mem [0:(1<<(RW+CW))-1];
    logic          exp_mode;
    logic          exp_dout;
    logic [RW-1:0] lrow;

    always #2.5 clk = ~clk;

    par_cmp_mem #(.ROW_W(RW), .COL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
        .we_n(we_n), .cas_n(cas_n), .row_addr(row_addr), .col_addr(col_addr),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic int flat(input logic [RW-1:0] r, input logic [CW-1:0] c);
        return int'({r, c});
    endfunction

    // Compare of the eight copies that differ only in the ignored bits.
    function automatic logic tm_read(input logic [RW-1:0] r, input logic [CW-1:0] c);
        logic first = ref_mem[flat({1'b0, r[RW-2:0]}, {1'b0, c[CW-2:1], 1'b0})];
        logic same = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic [RW-1:0] rr = {i[2], r[RW-2:0]};
            logic [CW-1:0] cc = {i[1], c[CW-2:1], i[0]};
            if (ref_mem[flat(rr, cc)] !== first) same = 1'b0;
        end
        return same;
    endfunction

    task automatic tm_write(input logic [RW-1:0] r, input logic [CW-1:0] c, input logic d);
        for (int i = 0; i < 8; i++) begin
            logic [RW-1:0] rr = {i[2], r[RW-2:0]};
            logic [CW-1:0] cc = {i[1], c[CW-2:1], i[0]};
            ref_mem[flat(rr, cc)] = d;
        end
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock of stimulus. The model is updated, then the outputs are checked after the edge.
    task automatic step(input logic [2:0] k, input logic [RW-1:0] r, input logic [CW-1:0] c,
                        input logic d, input logic w, input logic cs, input string req);
        logic [RW-1:0] er;
        cyc_valid = (k != K_IDLE);
        cyc_kind = k; row_addr = r; col_addr = c; din = d; we_n = w; cas_n = cs;
        er = (k == K_PRD || k == K_PWR) ? lrow : r;
        if (k == K_RD || k == K_RMW || k == K_PRD)
            exp_dout = exp_mode ? tm_read(er, c) : ref_mem[flat(er, c)];
        if (k == K_WR || k == K_RMW || k == K_PWR) begin
            if (exp_mode) tm_write(er, c, d);
            else ref_mem[flat(er, c)] = d;
        end
        if (k == K_RD || k == K_WR || k == K_RMW) lrow = r;
        if (k == K_CBR) exp_mode = !w;
        if (k == K_ROR) exp_mode = 1'b0;
        @(posedge clk);
        #1;
        check(req, "dout", dout, exp_dout);
        check("R10", "dout_en", dout_en, !cs);
        @(negedge clk);
    endtask

    task automatic rd(input logic [RW-1:0] r, input logic [CW-1:0] c, input string req);
        step(K_RD, r, c, 1'b0, 1'b1, 1'b0, req);
    endtask

    task automatic wr(input logic [RW-1:0] r, input logic [CW-1:0] c, input logic d, input string req);
        step(K_WR, r, c, d, 1'b0, 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << (RW + CW)); i++) ref_mem[i] = 1'b0;
        exp_mode = 1'b0; exp_dout = 1'b0; lrow = '0;
        repeat (3) @(negedge clk);
        // R1: dout cleared by reset, output disabled with CAS high.
        check("R1", "dout after reset", dout, 1'b0);
        check("R10", "dout_en cas high", dout_en, 1'b0);
        rst_n = 1'b1;
        // R1: array cleared.
        rd(5'd3, 5'd9, "R1");
        rd(5'd31, 5'd31, "R1");

        // R2: single-bit addressing, neighbours in other sections stay 0.
        wr(5'b10110, 5'b10011, 1'b1, "R2");
        rd(5'b10110, 5'b10011, "R2");
        rd(5'b00110, 5'b10011, "R2");
        rd(5'b10110, 5'b00011, "R2");
        rd(5'b10110, 5'b10010, "R2");
        wr(5'b00001, 5'b00000, 1'b1, "R2");
        rd(5'b00001, 5'b00000, "R2");
        // R11: refresh and idle codes leave data and dout alone.
        step(K_ROR, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, "R11");
        step(K_CBR, 5'd0, 5'd0, 1'b1, 1'b1, 1'b1, "R11");
        step(K_IDLE, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, "R11");
        rd(5'b10110, 5'b10011, "R11");
        // R4: CBR with we_n high in normal mode keeps single-bit reads.
        rd(5'b00110, 5'b10011, "R4");

        // R3: enter test mode.
        step(K_CBR, 5'd7, 5'd7, 1'b0, 1'b0, 1'b1, "R3");
        // R6: mixed copies at this offset -> 0.
        rd(5'b00110, 5'b00010, "R6");
        // R5/R7: parallel write with don't-care bits set, read with them cleared.
        wr(5'b11000, 5'b10101, 1'b1, "R5");
        rd(5'b01000, 5'b00100, "R7");
        rd(5'b11000, 5'b10101, "R6");
        // R6: all-zero offset passes.
        rd(5'b00011, 5'b01100, "R6");
        // R9: RMW in test mode returns pre-write compare and writes all copies.
        step(K_RMW, 5'b00110, 5'b10011, 1'b0, 1'b0, 1'b0, "R9");
        rd(5'b10110, 5'b00010, "R9");
        // R8: page read and write in test mode use latched row.
        step(K_PWR, 5'b11111, 5'b01110, 1'b1, 1'b0, 1'b0, "R8");
        step(K_PRD, 5'b00000, 5'b11111, 1'b0, 1'b1, 1'b0, "R8");
        // R4: exit by RAS-only refresh.
        step(K_ROR, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, "R4");
        wr(5'b00110, 5'b01110, 1'b0, "R4");
        rd(5'b10110, 5'b11111, "R4");
        // R6: one differing copy fails the compare after re-entry.
        step(K_CBR, 5'd1, 5'd1, 1'b0, 1'b0, 1'b1, "R3");
        rd(5'b00110, 5'b01110, "R6");
        // R4: exit by CBR with we_n high.
        step(K_CBR, 5'd1, 5'd1, 1'b0, 1'b1, 1'b1, "R4");
        rd(5'b10110, 5'b11111, "R4");
        // R8/R9 in normal mode.
        step(K_RMW, 5'b01010, 5'b00001, 1'b1, 1'b0, 1'b0, "R9");
        step(K_PRD, 5'b11111, 5'b00001, 1'b0, 1'b1, 1'b0, "R8");
        step(K_PWR, 5'b00000, 5'b00010, 1'b1, 1'b0, 1'b0, "R8");
        rd(5'b01010, 5'b00010, "R8");
        // R10: read with CAS high leaves the output disabled.
        step(K_RD, 5'b01010, 5'b00010, 1'b0, 1'b1, 1'b1, "R10");

        // Random mix on a few rows, all requirements against the model.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] k = 3'($urandom_range(0, 7));
            logic [RW-1:0] r = {1'($urandom), 2'b01, 2'($urandom)};
            logic [CW-1:0] c = {1'($urandom), 2'b10, 2'($urandom)};
            logic w = (k == K_CBR) ? 1'($urandom) : 1'b1;
            step(k, r, c, 1'($urandom), w, 1'($urandom), "R2");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule